// File: doc/BRIEF.md
# Trap and Exception Request Detector

This block inspects one 32-bit instruction word together with the two 64-bit register values already read for its rs and rt fields. It decides in the same cycle whether the instruction must raise an exception. A breakpoint or a system call always raises one. A conditional trap raises one only when its condition holds. The block also picks the matching cause code.

A return-from-exception instruction is not an exception. It is reported on its own flag so that the surrounding pipeline can start the return sequence.

The detector is purely combinational and sits between operand read and the exception logic of the pipeline. Vectoring to a handler, saving the faulting address, status registers and flushing all belong to other blocks. Cause encoding: 2'b00 none, 2'b01 breakpoint, 2'b10 system call, 2'b11 trap.

Top module: `exc_req_detect`

## Requirements
- R1: The word 32'h0000_000D raises an exception with cause 2'b01 (breakpoint). This word has opcode [31:26]=0, bits [25:6]=0 and function [5:0]=6'b001101.
- R2: The word 32'h0000_000C raises an exception with cause 2'b10 (system call). This word has opcode 0, bits [25:6]=0 and function 6'b001100.
- R3: A word with function 6'b001101 or 6'b001100 but any set bit in [31:6] is not a breakpoint and not a system call. At most one instruction class is recognised per word.
- R4: Trap-if-equal has opcode [31:26]=0 and function [5:0]=6'b110100, with bits [25:6] free. It raises cause 2'b11 exactly when rs_val equals rt_val over all 64 bits.
- R5: Trap-if-less-than-immediate has opcode [31:26]=6'b000001 and bits [20:16]=5'b01010. The immediate [15:0] is sign-extended to 64 bits. The instruction raises cause 2'b11 exactly when rs_val is less than that value in a signed comparison.
- R6: The word 32'h4200_0018 sets eret_flag and leaves exception_valid low with cause 2'b00. This word has opcode 6'b010000, bit 25 set, bits [24:6] clear and function 6'b011000.
- R7: Any other word, and a conditional trap whose condition is false, gives exception_valid=0, cause 2'b00 and eret_flag=0.
- R8: exception_valid is high exactly when the cause differs from 2'b00. exception_valid and eret_flag are never high together.
- R9: For breakpoint, system call and return-from-exception, the outputs do not depend on rs_val or rt_val.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn | input | 32 | Instruction word under inspection |
| rs_val | input | XLEN (64) | Value read for the rs field |
| rt_val | input | XLEN (64) | Value read for the rt field |
| exception_valid | output | 1 | Instruction raises an exception |
| exc_cause | output | 2 | Cause: 00 none, 01 breakpoint, 10 system call, 11 trap |
| eret_flag | output | 1 | Instruction is a return-from-exception |

## Verification
The assertions are immediate checks on a combinational block. They assume that insn, rs_val and rt_val are fully known whenever they are evaluated, so each one is guarded against unknown inputs. They also assume that the operand values belong to the rs and rt fields of the same word. The bench keeps to this by driving all three inputs together, one step after a clock edge, and it never leaves an input undriven after the first step. Random stimulus is drawn from templates of the recognised encodings, including near-miss words one bit away. This reaches every class, not only random noise, and the trap operands are placed around the equality and signed-threshold boundaries.

// File: rtl/exc_req_pkg.sv
package exc_req_pkg;

  localparam int INSN_W  = 32;
  localparam int IMM_W   = 16;
  localparam int FUNCT_W = 6;
  localparam int OPC_W   = 6;

  localparam logic [OPC_W-1:0]   OPC_SPECIAL = 6'b000000;
  localparam logic [OPC_W-1:0]   OPC_REGIMM  = 6'b000001;
  localparam logic [OPC_W-1:0]   OPC_SYSCTL  = 6'b010000;
  localparam logic [FUNCT_W-1:0] FN_BRK      = 6'b001101;
  localparam logic [FUNCT_W-1:0] FN_SYS      = 6'b001100;
  localparam logic [FUNCT_W-1:0] FN_TEQ      = 6'b110100;
  localparam logic [FUNCT_W-1:0] FN_RET      = 6'b011000;
  localparam logic [4:0]         RI_TLTI     = 5'b01010;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_BRK  = 2'b01,
    CAUSE_SYS  = 2'b10,
    CAUSE_TRAP = 2'b11
  } exc_cause_e;

  typedef struct packed {
    logic brk;
    logic sys;
    logic teq;
    logic tlti;
    logic ret;
  } insn_class_t;

  function automatic logic [OPC_W-1:0] opc_of(input logic [INSN_W-1:0] w);
    return w[31:26];
  endfunction

  function automatic logic [FUNCT_W-1:0] funct_of(input logic [INSN_W-1:0] w);
    return w[5:0];
  endfunction

  function automatic logic [4:0] rt_field_of(input logic [INSN_W-1:0] w);
    return w[20:16];
  endfunction

  // Breakpoint and system call need every bit outside the function field clear.
  function automatic logic fixed_special(input logic [INSN_W-1:0] w,
                                         input logic [FUNCT_W-1:0] fn);
    return (opc_of(w) == OPC_SPECIAL) && (w[25:6] == '0) && (funct_of(w) == fn);
  endfunction

  function automatic insn_class_t classify(input logic [INSN_W-1:0] w);
    insn_class_t c;
    c.brk  = fixed_special(w, FN_BRK);
    c.sys  = fixed_special(w, FN_SYS);
    c.teq  = (opc_of(w) == OPC_SPECIAL) && (funct_of(w) == FN_TEQ);
    c.tlti = (opc_of(w) == OPC_REGIMM) && (rt_field_of(w) == RI_TLTI);
    c.ret  = (w == {OPC_SYSCTL, 1'b1, 19'b0, FN_RET});
    return c;
  endfunction

endpackage

// File: rtl/exc_req_decode.sv
module exc_req_decode
  import exc_req_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output insn_class_t       cls,
  output logic [IMM_W-1:0]  imm
);

  always_comb begin
    cls = classify(insn);
    imm = insn[IMM_W-1:0];
  end

endmodule

// File: rtl/exc_req_cond.sv
module exc_req_cond #(
  parameter int XLEN   = 64,
  parameter int IMM_W  = 16,
  parameter int LANE_W = 16
) (
  input  logic [XLEN-1:0]  rs_val,
  input  logic [XLEN-1:0]  rt_val,
  input  logic [IMM_W-1:0] imm,
  output logic             eq_hit,
  output logic             lt_hit
);

  localparam int EXT_W = XLEN - IMM_W;
  localparam int LANES = XLEN / LANE_W;

  function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] v);
    return {{EXT_W{v[IMM_W-1]}}, v};
  endfunction

  function automatic logic signed_below(input logic [XLEN-1:0] a,
                                        input logic [XLEN-1:0] b);
    return $signed(a) < $signed(b);
  endfunction

  // Equality is reduced per lane, then the lane results are and-ed together.
  logic [LANES-1:0] lane_eq;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_eq[g] = (rs_val[g*LANE_W +: LANE_W] == rt_val[g*LANE_W +: LANE_W]);
  end

  assign eq_hit = &lane_eq;
  assign lt_hit = signed_below(rs_val, sext_imm(imm));

endmodule

// File: rtl/exc_req_merge.sv
module exc_req_merge
  import exc_req_pkg::*;
(
  input  insn_class_t cls,
  input  logic        eq_hit,
  input  logic        lt_hit,
  output logic        exception_valid,
  output logic [1:0]  exc_cause,
  output logic        eret_flag,
  output logic        trap_fire
);

  exc_cause_e cause;

  always_comb begin
    trap_fire = (cls.teq && eq_hit) || (cls.tlti && lt_hit);
    if (cls.brk)       cause = CAUSE_BRK;
    else if (cls.sys)  cause = CAUSE_SYS;
    else if (trap_fire) cause = CAUSE_TRAP;
    else               cause = CAUSE_NONE;
    exc_cause       = cause;
    exception_valid = (cause != CAUSE_NONE);
    eret_flag       = cls.ret;
  end

endmodule

// File: rtl/exc_req_detect.sv
module exc_req_detect
  import exc_req_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [31:0]     insn,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  output logic            exception_valid,
  output logic [1:0]      exc_cause,
  output logic            eret_flag
);

  insn_class_t      cls;
  logic [IMM_W-1:0] imm_field;
  logic             eq_hit;
  logic             lt_hit;
  logic             trap_fire;

  exc_req_decode u_decode (
    .insn (insn),
    .cls  (cls),
    .imm  (imm_field)
  );

  exc_req_cond #(.XLEN(XLEN), .IMM_W(IMM_W), .LANE_W(16)) u_cond (
    .rs_val (rs_val),
    .rt_val (rt_val),
    .imm    (imm_field),
    .eq_hit (eq_hit),
    .lt_hit (lt_hit)
  );

  exc_req_merge u_merge (
    .cls             (cls),
    .eq_hit          (eq_hit),
    .lt_hit          (lt_hit),
    .exception_valid (exception_valid),
    .exc_cause       (exc_cause),
    .eret_flag       (eret_flag),
    .trap_fire       (trap_fire)
  );

endmodule

// File: rtl/exc_req_detect_chk.sv
module exc_req_detect_chk
  import exc_req_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic [31:0]     insn,
  input logic [XLEN-1:0] rs_val,
  input logic [XLEN-1:0] rt_val,
  input logic            exception_valid,
  input logic [1:0]      exc_cause,
  input logic            eret_flag,
  input insn_class_t     cls,
  input logic            eq_hit,
  input logic            lt_hit,
  input logic            trap_fire
);

  logic known;
  assign known = !$isunknown({insn, rs_val, rt_val});

  always_comb begin
    if (known) begin
      AST_VALID_IFF_CAUSE: assert (exception_valid == (exc_cause != 2'b00)); // R8
      AST_ERET_NOT_EXC: assert (!(eret_flag && exception_valid)); // R6
      AST_BREAK_WORD: assert ((exc_cause != 2'b01) || (insn == 32'h0000_000D)); // R1
      AST_SYSCALL_WORD: assert ((exc_cause != 2'b10) || (insn == 32'h0000_000C)); // R2
      AST_ONE_CLASS: assert ($onehot0(cls)); // R3
      AST_TRAP_NEEDS_HIT: assert ((exc_cause != 2'b11) || trap_fire); // R7
      AST_TRAP_HIT_KIND: assert (!trap_fire || (cls.teq && eq_hit) || (cls.tlti && lt_hit)); // R7
      AST_TEQ_FIRES: assert (!(cls.teq && (rs_val == rt_val)) || (exc_cause == 2'b11)); // R4
      AST_TLTI_FIRES: assert (!(cls.tlti && ($signed(rs_val) < $signed(insn[15:0])))
                              || (exc_cause == 2'b11)); // R5
    end
  end

endmodule

bind exc_req_detect exc_req_detect_chk #(.XLEN(XLEN)) u_chk (
  .insn            (insn),
  .rs_val          (rs_val),
  .rt_val          (rt_val),
  .exception_valid (exception_valid),
  .exc_cause       (exc_cause),
  .eret_flag       (eret_flag),
  .cls             (cls),
  .eq_hit          (eq_hit),
  .lt_hit          (lt_hit),
  .trap_fire       (trap_fire)
);

// File: tb/exc_req_detect_bench.sv
module exc_req_detect_bench;

  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic [31:0]     insn;
  logic [XLEN-1:0] rs_val;
  logic [XLEN-1:0] rt_val;
  logic            exception_valid;
  logic [1:0]      exc_cause;
  logic            eret_flag;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  exc_req_detect #(.XLEN(XLEN)) u_exc_req_detect (
    .insn            (insn),
    .rs_val          (rs_val),
    .rt_val          (rt_val),
    .exception_valid (exception_valid),
    .exc_cause       (exc_cause),
    .eret_flag       (eret_flag)
  );

  // Reference model: returns {valid, cause[1:0], eret}.
  function automatic logic [3:0] model(input logic [31:0] w,
                                       input logic [63:0] a,
                                       input logic [63:0] b);
    longint sa;
    longint si;
    sa = longint'(a);
    si = longint'(shortint'(w[15:0]));
    if (w == 32'h0000_000D) return 4'b1_01_0;
    if (w == 32'h0000_000C) return 4'b1_10_0;
    if (w == 32'h4200_0018) return 4'b0_00_1;
    if (w[31:26] == 6'd0 && w[5:0] == 6'h34)
      return (a == b) ? 4'b1_11_0 : 4'b0_00_0;
    if (w[31:26] == 6'd1 && w[20:16] == 5'h0A)
      return (sa < si) ? 4'b1_11_0 : 4'b0_00_0;
    return 4'b0_00_0;
  endfunction

  task automatic apply(input string req, input logic [31:0] w,
                       input logic [63:0] a, input logic [63:0] b);
    logic [3:0] exp_v;
    logic [3:0] act_v;
    @(posedge clk);
    #1;
    insn = w; rs_val = a; rt_val = b;
    @(negedge clk);
    exp_v = model(w, a, b);
    act_v = {exception_valid, exc_cause, eret_flag};
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s insn=%h rs=%h rt=%h actual=%b expected=%b",
               req, w, a, b, act_v, exp_v);
    end
  endtask

  function automatic logic [31:0] teq_word(input logic [19:0] mid);
    return {6'd0, mid, 6'h34};
  endfunction

  function automatic logic [31:0] tlti_word(input logic [4:0] rs_f, input logic [15:0] im);
    return {6'd1, rs_f, 5'h0A, im};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    insn = '0; rs_val = '0; rt_val = '0;
    repeat (2) @(posedge clk);
    // R7: idle state with an all-zero word
    apply("R7 reset nop", 32'h0, 64'h0, 64'h0);
    apply("R1 break", 32'h0000_000D, 64'h0, 64'h0);
    apply("R2 syscall", 32'h0000_000C, 64'h0, 64'h0);
    apply("R9 break ops", 32'h0000_000D, 64'h1234, 64'hFFFF_0000_0000_0000);
    apply("R9 syscall ops", 32'h0000_000C, 64'hDEAD_BEEF, 64'h5);
    apply("R3 break mid bit", 32'h0000_004D, 64'h0, 64'h0);
    apply("R3 syscall opc bit", 32'h0400_000C, 64'h0, 64'h0);
    apply("R4 teq equal", teq_word(20'hABCDE), 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0001);
    apply("R4 teq top bit differs", teq_word(20'h0), 64'h8000_0000_0000_0000, 64'h0);
    apply("R4 teq low bit differs", teq_word(20'h1), 64'h1, 64'h0);
    apply("R5 tlti equal no trap", tlti_word(5'd3, 16'h0010), 64'h10, 64'h0);
    apply("R5 tlti below traps", tlti_word(5'd3, 16'h0010), 64'hF, 64'h0);
    apply("R5 tlti signed neg rs", tlti_word(5'd0, 16'h0000), 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
    apply("R5 tlti neg imm", tlti_word(5'd1, 16'h8000), 64'hFFFF_FFFF_FFFF_7FFF, 64'h0);
    apply("R5 tlti neg imm equal", tlti_word(5'd1, 16'h8000), 64'hFFFF_FFFF_FFFF_8000, 64'h0);
    apply("R5 tlti large pos rs", tlti_word(5'd1, 16'h7FFF), 64'h0000_0001_0000_0000, 64'h0);
    apply("R6 eret", 32'h4200_0018, 64'h0, 64'h0);
    apply("R9 eret ops", 32'h4200_0018, 64'h77, 64'h77);
    apply("R6 eret near miss", 32'h4200_0019, 64'h0, 64'h0);
    apply("R7 other word", 32'h2108_0005, 64'h0, 64'h0);

    for (int i = 0; i < 3000; i++) begin
      int kind;
      logic [31:0] w;
      logic [63:0] a;
      logic [63:0] b;
      string tag;
      kind = $urandom_range(0, 7);
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      w = $urandom;
      tag = "R7 random";
      case (kind)
        1: begin
          w = teq_word(20'($urandom));
          if ($urandom_range(0, 1) == 0) b = a;
          tag = "R4 random teq";
        end
        2: begin
          w = tlti_word(5'($urandom), 16'($urandom));
          a = 64'(longint'(shortint'(w[15:0])) + longint'($urandom_range(0, 2)) - 64'sd1);
          tag = "R5 random tlti";
        end
        3: begin w = 32'h0000_000D; tag = "R9 random break"; end
        4: begin w = 32'h0000_000C; tag = "R9 random syscall"; end
        5: begin w = 32'h4200_0018; tag = "R9 random eret"; end
        6: begin
          w = (($urandom_range(0, 1) == 0) ? 32'h0000_000D : 32'h0000_000C)
              ^ (32'h1 << $urandom_range(6, 31));
          tag = "R3 random near miss";
        end
        7: begin
          w = 32'h4200_0018 ^ (32'h1 << $urandom_range(0, 31));
          tag = "R6 random eret near miss";
        end
        default: ;
      endcase
      apply(tag, w, a, b);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule